// File: doc/BRIEF.md
# Sixteen-bit ALU with status-flag update

This block is the purely combinational execute datapath of a small sixteen-bit RISC core. Each cycle the decoder presents an operation code, two register operands, a four-bit immediate field and the current status word. In the same cycle the block returns the result value, the next status word and a three-bit mask that says which condition flags the operation defines. The register file commits the result and the status word on its own clock edge.

Register forms compute `rD = opa OP opb`. Single-operand forms (negate, not, pass) use `opa`. Short-immediate forms take the destination register's current value on `opb` and combine it with the decoded immediate. Compare forms subtract, return the difference on `result` so the caller can discard it, and report carry as an unsigned borrow. The interrupt-enable bits pass through untouched. The unused upper bits of the status word always leave the block as zero.

Top module: `alu16_core`

## Requirements
- R1: The status word keeps N at bit 4, C at bit 3, Z at bit 2 and the two interrupt enables at bits 1 and 0. `sr_out[1:0]` always equals `sr_in[1:0]`, and `sr_out[15:5]` is always zero. `flag_we` is ordered {N, C, Z} from bit 2 down to bit 0.
- R2: add (op 0) and add-with-carry (op 1) return the 16-bit sum of `opa` and `opb`. Add-with-carry also adds `sr_in[3]`. Both set C to the carry out of bit 15 and write all three flags.
- R3: and (op 2), or (op 3) and xor (op 4) return the bitwise result. They write N and Z from that result, and `sr_out[3]` equals `sr_in[3]`.
- R4: lsl (op 5), lsr (op 6) and asr (op 7) shift `opa` by the count on `opb`. C takes the last bit shifted out. asr fills the vacated bits with `opa[15]`.
- R5: A register shift by a count of zero returns `opa` unchanged, clears `flag_we[1]` and keeps C.
- R6: A register shift count of 16 or more returns zero, or sixteen copies of the sign bit for asr. C is the bit that would leave last: `opa[0]` for lsl at exactly 16, zero for lsl and lsr beyond that, and the sign bit for asr.
- R7: compare (op 10) returns `opb - opa`. It writes all three flags, and C is set exactly when `opb < opa` unsigned.
- R8: add-immediate (op 11), and-immediate (op 12) and or-immediate (op 13) combine `opb` with the immediate. The immediate is the signed four-bit code, except that code 0 stands for +8. The add form sets C from the carry out, and the logic forms keep C.
- R9: The immediate shifts, lsl (op 14) and lsr (op 15), shift `opb` by the immediate code, with code 0 standing for 8. C takes the last bit shifted out.
- R10: compare-immediate (op 16) returns `opb` minus the plainly sign-extended code (-8 to 7). C is the unsigned borrow against that 16-bit value.
- R11: negate (op 8) returns the two's complement of `opa`, and not (op 9) returns the one's complement. Both write N and Z and keep C.
- R12: pass (op 17) and every unassigned code (18 to 31) return `opa` with `flag_we` zero, so the N, C and Z bits of `sr_out` equal those of `sr_in`.
- R13: Whenever a flag is written, N equals `result[15]` and Z is set exactly when `result` is zero. An unwritten flag is copied from `sr_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation code |
| opa | input | 16 | First (source) operand |
| opb | input | 16 | Second operand, or the destination value for immediate forms |
| imm | input | 4 | Packed short-immediate field |
| sr_in | input | 16 | Current status word |
| result | output | 16 | Operation result (difference for compares) |
| sr_out | output | 16 | Next status word |
| flag_we | output | 3 | Flags defined by this operation, {N, C, Z} |

## Verification
The scoreboard feeds hand-worked corner vectors and then a few hundred pseudo-random ones through an independent bit-serial reference. Wrap-around sums separate carry-out from the zero flag. Compares with both operand orders separate borrow from carry. Shift counts of 0, 1, 16, 17 and 20 separate the no-shift, normal and saturated paths. Immediate codes 0, 8 and 15 separate the "zero means eight" decode from plain sign extension. Starting with the carry bit set shows which operations keep C and which overwrite it.

// File: rtl/alu16_pkg.sv
`timescale 1ns/1ps
package alu16_pkg;
   localparam int OP_W = 5;

   // status word bit positions
   localparam int SR_N   = 4;
   localparam int SR_C   = 3;
   localparam int SR_Z   = 2;
   localparam int SR_IE1 = 1;
   localparam int SR_IE0 = 0;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 5'd0,
      OP_ADC  = 5'd1,
      OP_AND  = 5'd2,
      OP_OR   = 5'd3,
      OP_XOR  = 5'd4,
      OP_LSL  = 5'd5,
      OP_LSR  = 5'd6,
      OP_ASR  = 5'd7,
      OP_NEG  = 5'd8,
      OP_NOT  = 5'd9,
      OP_CMP  = 5'd10,
      OP_ADDI = 5'd11,
      OP_ANDI = 5'd12,
      OP_ORI  = 5'd13,
      OP_LSLI = 5'd14,
      OP_LSRI = 5'd15,
      OP_CMPI = 5'd16,
      OP_PASS = 5'd17
   } alu_op_e;

   typedef enum logic [1:0] {
      SH_LSL = 2'd0,
      SH_LSR = 2'd1,
      SH_ASR = 2'd2
   } shift_kind_e;

   typedef enum logic [1:0] {
      SRC_PASS  = 2'd0,
      SRC_ADD   = 2'd1,
      SRC_LOGIC = 2'd2,
      SRC_SHIFT = 2'd3
   } res_src_e;

   typedef struct packed {
      logic n;
      logic c;
      logic z;
   } flag_set_t;
endpackage

// File: rtl/alu16_immdec.sv
`timescale 1ns/1ps
module alu16_immdec #(
   parameter int WIDTH = 16,
   parameter int IMM_W = 4
) (
   input  logic [IMM_W-1:0] imm,
   output logic [WIDTH-1:0] imm_nz,   // signed, code 0 -> +HALF
   output logic [WIDTH-1:0] imm_sx,   // plain sign extension
   output logic [WIDTH-1:0] imm_cnt   // unsigned count, code 0 -> HALF
);
   localparam int HALF = 1 << (IMM_W - 1);
   localparam int PAD  = WIDTH - IMM_W;

   logic code_zero;
   assign code_zero = (imm == '0);

   assign imm_sx  = {{PAD{imm[IMM_W-1]}}, imm};
   assign imm_nz  = code_zero ? WIDTH'(HALF) : imm_sx;
   assign imm_cnt = code_zero ? WIDTH'(HALF) : {{PAD{1'b0}}, imm};
endmodule

// File: rtl/alu16_adder.sv
`timescale 1ns/1ps
module alu16_adder #(
   parameter int WIDTH  = 16,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             ci,
   output logic [WIDTH-1:0] sum,
   output logic             co
);
   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] cy;
         assign cy[0] = ci;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]  = x[i] ^ y[i] ^ cy[i];
            assign cy[i+1] = (x[i] & y[i]) | (cy[i] & (x[i] ^ y[i]));
         end
         assign co = cy[WIDTH];
      end else begin : g_infer
         logic [WIDTH:0] wide;
         assign wide = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, ci};
         assign sum  = wide[WIDTH-1:0];
         assign co   = wide[WIDTH];
      end
   endgenerate
endmodule

// File: rtl/alu16_shifter.sv
`timescale 1ns/1ps
module alu16_shifter
   import alu16_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] val,
   input  logic [WIDTH-1:0] amt,
   input  shift_kind_e      kind,
   output logic [WIDTH-1:0] res,
   output logic             cout,
   output logic             c_valid
);
   // shifting by amt-1 leaves the last outgoing bit at the edge
   logic [WIDTH-1:0] amt_m1;
   logic [WIDTH-1:0] pre_l, pre_r, pre_a;
   logic [WIDTH-1:0] full_l, full_r, full_a;

   assign amt_m1 = amt - WIDTH'(1);
   assign pre_l  = val << amt_m1;
   assign pre_r  = val >> amt_m1;
   assign pre_a  = WIDTH'($signed(val) >>> amt_m1);
   assign full_l = val << amt;
   assign full_r = val >> amt;
   assign full_a = WIDTH'($signed(val) >>> amt);

   assign c_valid = (amt != '0);

   always_comb begin
      unique case (kind)
         SH_LSR: begin
            res  = full_r;
            cout = pre_r[0];
         end
         SH_ASR: begin
            res  = full_a;
            cout = pre_a[0];
         end
         default: begin
            res  = full_l;
            cout = pre_l[WIDTH-1];
         end
      endcase
      if (!c_valid) begin
         res  = val;
         cout = 1'b0;
      end
   end
endmodule

// File: rtl/alu16_flags.sv
`timescale 1ns/1ps
module alu16_flags
   import alu16_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] res,
   input  logic             c_new,
   input  flag_set_t        we,
   input  logic [WIDTH-1:0] sr_prev,
   output logic [WIDTH-1:0] sr_next
);
   logic n_new, z_new;
   logic unused_hi;

   assign n_new     = res[WIDTH-1];
   assign z_new     = (res == '0);
   assign unused_hi = ^sr_prev[WIDTH-1:SR_N+1];

   always_comb begin
      sr_next         = '0;
      sr_next[SR_IE0] = sr_prev[SR_IE0];
      sr_next[SR_IE1] = sr_prev[SR_IE1];
      sr_next[SR_N]   = we.n ? n_new : sr_prev[SR_N];
      sr_next[SR_C]   = we.c ? c_new : sr_prev[SR_C];
      sr_next[SR_Z]   = we.z ? z_new : sr_prev[SR_Z];
   end
endmodule

// File: rtl/alu16_core.sv
`timescale 1ns/1ps
module alu16_core
   import alu16_pkg::*;
#(
   parameter int WIDTH  = 16,
   parameter int IMM_W  = 4,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [OP_W-1:0]  op_sel,
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic [IMM_W-1:0] imm,
   input  logic [WIDTH-1:0] sr_in,
   output logic [WIDTH-1:0] result,
   output logic [WIDTH-1:0] sr_out,
   output logic [2:0]       flag_we
);
   generate
      if (WIDTH < 8) begin : g_bad_width
         $error("alu16_core: WIDTH must be at least 8");
      end
      if (IMM_W < 2 || IMM_W >= WIDTH) begin : g_bad_imm
         $error("alu16_core: IMM_W must lie in 2..WIDTH-1");
      end
   endgenerate

   alu_op_e op;
   assign op = alu_op_e'(op_sel);

   logic [WIDTH-1:0] imm_nz, imm_sx, imm_cnt;
   logic [WIDTH-1:0] add_x, add_y, add_sum;
   logic             add_ci, add_co, inv_c;
   logic [WIDTH-1:0] sh_val, sh_amt, sh_res;
   logic             sh_co, sh_cv, is_shift;
   shift_kind_e      sh_kind;
   logic [WIDTH-1:0] logic_r;
   res_src_e         src;
   flag_set_t        we_raw, we_fin;
   logic             c_new;

   alu16_immdec #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_immdec (
      .imm     (imm),
      .imm_nz  (imm_nz),
      .imm_sx  (imm_sx),
      .imm_cnt (imm_cnt)
   );

   alu16_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_adder (
      .x   (add_x),
      .y   (add_y),
      .ci  (add_ci),
      .sum (add_sum),
      .co  (add_co)
   );

   alu16_shifter #(.WIDTH(WIDTH)) u_shifter (
      .val     (sh_val),
      .amt     (sh_amt),
      .kind    (sh_kind),
      .res     (sh_res),
      .cout    (sh_co),
      .c_valid (sh_cv)
   );

   // operand steering and flag mask per operation
   always_comb begin
      add_x    = opa;
      add_y    = opb;
      add_ci   = 1'b0;
      inv_c    = 1'b0;
      sh_val   = opa;
      sh_amt   = opb;
      sh_kind  = SH_LSL;
      is_shift = 1'b0;
      logic_r  = opa;
      src      = SRC_PASS;
      we_raw   = '{n: 1'b0, c: 1'b0, z: 1'b0};
      unique case (op)
         OP_ADD, OP_ADC: begin
            add_ci = (op == OP_ADC) ? sr_in[SR_C] : 1'b0;
            src    = SRC_ADD;
            we_raw = '{n: 1'b1, c: 1'b1, z: 1'b1};
         end
         OP_CMP: begin
            add_x  = opb;
            add_y  = ~opa;
            add_ci = 1'b1;
            inv_c  = 1'b1;
            src    = SRC_ADD;
            we_raw = '{n: 1'b1, c: 1'b1, z: 1'b1};
         end
         OP_NEG: begin
            add_x  = ~opa;
            add_y  = '0;
            add_ci = 1'b1;
            src    = SRC_ADD;
            we_raw = '{n: 1'b1, c: 1'b0, z: 1'b1};
         end
         OP_ADDI: begin
            add_x  = opb;
            add_y  = imm_nz;
            src    = SRC_ADD;
            we_raw = '{n: 1'b1, c: 1'b1, z: 1'b1};
         end
         OP_CMPI: begin
            add_x  = opb;
            add_y  = ~imm_sx;
            add_ci = 1'b1;
            inv_c  = 1'b1;
            src    = SRC_ADD;
            we_raw = '{n: 1'b1, c: 1'b1, z: 1'b1};
         end
         OP_AND, OP_OR, OP_XOR, OP_NOT, OP_ANDI, OP_ORI: begin
            unique case (op)
               OP_AND:  logic_r = opa & opb;
               OP_OR:   logic_r = opa | opb;
               OP_XOR:  logic_r = opa ^ opb;
               OP_NOT:  logic_r = ~opa;
               OP_ANDI: logic_r = opb & imm_nz;
               default: logic_r = opb | imm_nz;
            endcase
            src    = SRC_LOGIC;
            we_raw = '{n: 1'b1, c: 1'b0, z: 1'b1};
         end
         OP_LSL, OP_LSR, OP_ASR: begin
            sh_kind  = (op == OP_LSL) ? SH_LSL :
                       (op == OP_LSR) ? SH_LSR : SH_ASR;
            is_shift = 1'b1;
            src      = SRC_SHIFT;
            we_raw   = '{n: 1'b1, c: 1'b0, z: 1'b1};
         end
         OP_LSLI, OP_LSRI: begin
            sh_val   = opb;
            sh_amt   = imm_cnt;
            sh_kind  = (op == OP_LSLI) ? SH_LSL : SH_LSR;
            is_shift = 1'b1;
            src      = SRC_SHIFT;
            we_raw   = '{n: 1'b1, c: 1'b0, z: 1'b1};
         end
         default: begin
            src = SRC_PASS;
         end
      endcase
   end

   // shift carry is defined only when something actually moved
   assign we_fin = '{n: we_raw.n, c: we_raw.c | (is_shift & sh_cv), z: we_raw.z};
   assign c_new  = (src == SRC_SHIFT) ? sh_co : (add_co ^ inv_c);

   always_comb begin
      unique case (src)
         SRC_ADD:   result = add_sum;
         SRC_LOGIC: result = logic_r;
         SRC_SHIFT: result = sh_res;
         default:   result = opa;
      endcase
   end

   alu16_flags #(.WIDTH(WIDTH)) u_flags (
      .res     (result),
      .c_new   (c_new),
      .we      (we_fin),
      .sr_prev (sr_in),
      .sr_next (sr_out)
   );

   assign flag_we = {we_fin.n, we_fin.c, we_fin.z};
endmodule

// File: rtl/alu16_core_chk.sv
`timescale 1ns/1ps
module alu16_core_chk
   import alu16_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input logic [OP_W-1:0]  op_sel,
   input logic [WIDTH-1:0] opa,
   input logic [WIDTH-1:0] result,
   input logic [WIDTH-1:0] sr_in,
   input logic [WIDTH-1:0] sr_out,
   input logic [2:0]       flag_we
);
   always_comb begin
      // R1
      upper_zero_chk: assert (sr_out[WIDTH-1:SR_N+1] == '0)
         else $error("status upper bits not zero");
      // R1
      ie_keep_chk: assert (sr_out[SR_IE1:SR_IE0] == sr_in[SR_IE1:SR_IE0])
         else $error("interrupt enables altered");
      // R13
      n_match_chk: assert (!flag_we[2] || sr_out[SR_N] == result[WIDTH-1])
         else $error("written N disagrees with result");
      // R13
      z_match_chk: assert (!flag_we[0] || sr_out[SR_Z] == (result == '0))
         else $error("written Z disagrees with result");
      // R13
      keep_flags_chk: assert ((flag_we[2] || sr_out[SR_N] == sr_in[SR_N]) &&
                              (flag_we[1] || sr_out[SR_C] == sr_in[SR_C]) &&
                              (flag_we[0] || sr_out[SR_Z] == sr_in[SR_Z]))
         else $error("unwritten flag changed");
      // R3
      logic_keep_c_chk: assert (!(op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR) ||
                                !flag_we[1])
         else $error("logic op wrote carry");
      // R12
      pass_chk: assert (op_sel <= OP_CMPI || (result == opa && flag_we == 3'b000))
         else $error("pass op changed value or flags");
   end
endmodule

bind alu16_core alu16_core_chk #(.WIDTH(WIDTH)) u_chk (
   .op_sel  (op_sel),
   .opa     (opa),
   .result  (result),
   .sr_in   (sr_in),
   .sr_out  (sr_out),
   .flag_we (flag_we)
);

// File: tb/alu16_core_test.sv
`timescale 1ns/1ps
module alu16_core_test;
   import alu16_pkg::*;

   typedef struct packed {
      logic [15:0] res;
      logic [15:0] sr;
      logic [2:0]  we;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [4:0]  op_sel = 5'd17;
   logic [15:0] opa = '0, opb = '0, sr_in = '0;
   logic [3:0]  imm = '0;
   logic [15:0] result, sr_out;
   logic [2:0]  flag_we;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   exp_t  exp_q[$];
   string tag_q[$];

   always #4 clk = ~clk;  // 125 MHz

   alu16_core uut (
      .op_sel  (op_sel),
      .opa     (opa),
      .opb     (opb),
      .imm     (imm),
      .sr_in   (sr_in),
      .result  (result),
      .sr_out  (sr_out),
      .flag_we (flag_we)
   );

   // bit-serial reference built from the requirements
   function automatic exp_t model(input logic [4:0] op, input logic [15:0] a, b, sr,
                                  input logic [3:0] im);
      exp_t e;
      logic [16:0] t;
      logic [15:0] r, v, sh;
      logic c;
      logic [2:0] we;
      int cnt, mode, iv;
      c = sr[3]; r = a; we = 3'b000; cnt = -1; mode = 0; sh = a;
      iv = (im == 0) ? 8 : ((im >= 8) ? int'(im) - 16 : int'(im));
      v  = 16'(iv);
      case (op)
         5'd0: begin t = {1'b0, a} + {1'b0, b}; r = t[15:0]; c = t[16]; we = 3'b111; end
         5'd1: begin t = {1'b0, a} + {1'b0, b} + {16'd0, sr[3]}; r = t[15:0]; c = t[16]; we = 3'b111; end
         5'd2: begin r = a & b; we = 3'b101; end
         5'd3: begin r = a | b; we = 3'b101; end
         5'd4: begin r = a ^ b; we = 3'b101; end
         5'd5, 5'd6, 5'd7: begin
            mode = int'(op) - 5; sh = a; cnt = (b > 16'd24) ? 24 : int'(b);
         end
         5'd8: begin r = 16'd0 - a; we = 3'b101; end
         5'd9: begin r = ~a; we = 3'b101; end
         5'd10: begin r = b - a; c = (b < a); we = 3'b111; end
         5'd11: begin t = {1'b0, b} + {1'b0, v}; r = t[15:0]; c = t[16]; we = 3'b111; end
         5'd12: begin r = b & v; we = 3'b101; end
         5'd13: begin r = b | v; we = 3'b101; end
         5'd14, 5'd15: begin
            mode = int'(op) - 14; sh = b; cnt = (im == 0) ? 8 : int'(im);
         end
         5'd16: begin
            v = 16'((im >= 8) ? int'(im) - 16 : int'(im));
            r = b - v; c = (b < v); we = 3'b111;
         end
         default: begin r = a; we = 3'b000; end
      endcase
      if (cnt >= 0) begin
         for (int k = 0; k < cnt; k++) begin
            if (mode == 0) begin c = sh[15]; sh = {sh[14:0], 1'b0}; end
            else if (mode == 1) begin c = sh[0]; sh = {1'b0, sh[15:1]}; end
            else begin c = sh[0]; sh = {sh[15], sh[15:1]}; end
         end
         r  = sh;
         we = (cnt == 0) ? 3'b101 : 3'b111;
      end
      e.res = r;
      e.we  = we;
      e.sr  = {11'd0, we[2] ? r[15] : sr[4], we[1] ? c : sr[3],
               we[0] ? (r == 16'd0) : sr[2], sr[1:0]};
      return e;
   endfunction

   task automatic apply(input logic [4:0] op, input logic [15:0] a, b, sr, input logic [3:0] im);
      @(posedge clk);
      op_sel = op; opa = a; opb = b; sr_in = sr; imm = im;
   endtask

   task automatic drive(input logic [4:0] op, input logic [15:0] a, b, sr,
                        input logic [3:0] im, input string tag);
      apply(op, a, b, sr, im);
      exp_q.push_back(model(op, a, b, sr, im));
      tag_q.push_back(tag);
   endtask

   task automatic drive_exp(input logic [4:0] op, input logic [15:0] a, b, sr,
                            input logic [3:0] im, input logic [15:0] xr, xs,
                            input logic [2:0] xw, input string tag);
      exp_t e;
      apply(op, a, b, sr, im);
      e.res = xr; e.sr = xs; e.we = xw;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   // monitor: compare away from the driving edge
   initial begin
      forever begin
         @(negedge clk);
         if (exp_q.size() > 0) begin
            exp_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (result !== e.res || sr_out !== e.sr || flag_we !== e.we) begin
               fails++;
               $display("FAIL %s: result=%h/%h sr_out=%h/%h flag_we=%b/%b (actual/expected)",
                        t, result, e.res, sr_out, e.sr, flag_we, e.we);
            end
         end
      end
   end

   initial begin
      #800000;
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: run did not finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] lfsr;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // R12 idle state after reset
      drive_exp(5'd17, 16'h0000, 16'h0000, 16'h0000, 4'h0, 16'h0000, 16'h0000, 3'b000, "R12 reset idle");
      // R2 wrap to zero
      drive_exp(5'd0, 16'hFFFF, 16'h0001, 16'h0000, 4'h0, 16'h0000, 16'h000C, 3'b111, "R2 add wrap");
      drive_exp(5'd1, 16'hFFFF, 16'h0000, 16'h0008, 4'h0, 16'h0000, 16'h000C, 3'b111, "R2 adc carry-in");
      // R7 borrow both orders
      drive_exp(5'd10, 16'h0005, 16'h0003, 16'h0000, 4'h0, 16'hFFFE, 16'h0018, 3'b111, "R7 cmp less");
      drive_exp(5'd10, 16'h0003, 16'h0005, 16'h0003, 4'h0, 16'h0002, 16'h0003, 3'b111, "R7 cmp greater, R1 enables");
      // R8 immediate decode
      drive_exp(5'd11, 16'h0000, 16'h0001, 16'h0000, 4'h0, 16'h0009, 16'h0000, 3'b111, "R8 addi code0=+8");
      drive_exp(5'd11, 16'h0000, 16'h0008, 16'h0000, 4'h8, 16'h0000, 16'h000C, 3'b111, "R8 addi code8=-8");
      // R4 / R6 shifts
      drive_exp(5'd6, 16'h0003, 16'h0001, 16'h0000, 4'h0, 16'h0001, 16'h0008, 3'b111, "R4 lsr by 1");
      drive_exp(5'd7, 16'h8001, 16'd20, 16'h0000, 4'h0, 16'hFFFF, 16'h0018, 3'b111, "R6 asr by 20");
      drive_exp(5'd5, 16'h0001, 16'd16, 16'h0000, 4'h0, 16'h0000, 16'h000C, 3'b111, "R6 lsl by 16");
      drive_exp(5'd5, 16'h0001, 16'd17, 16'h0008, 4'h0, 16'h0000, 16'h0004, 3'b111, "R6 lsl by 17");
      // R5 zero count
      drive_exp(5'd5, 16'h1234, 16'd0, 16'h0008, 4'h0, 16'h1234, 16'h0008, 3'b101, "R5 shift by 0");
      // R3 keeps carry
      drive_exp(5'd2, 16'hF0F0, 16'h0F0F, 16'h0008, 4'h0, 16'h0000, 16'h000C, 3'b101, "R3 and keeps C");
      // R9 immediate shift of 8
      drive_exp(5'd14, 16'h0000, 16'h0101, 16'h0000, 4'h0, 16'h0100, 16'h0008, 3'b111, "R9 lsli code0=8");
      // R10 compare immediate -1
      drive_exp(5'd16, 16'h0000, 16'h0000, 16'h0000, 4'hF, 16'h0001, 16'h0008, 3'b111, "R10 cmpi -1");
      // R11 negate of most negative keeps C
      drive_exp(5'd8, 16'h8000, 16'h0000, 16'h0008, 4'h0, 16'h8000, 16'h0018, 3'b101, "R11 neg 8000");
      drive_exp(5'd9, 16'hFFFF, 16'h0000, 16'h0000, 4'h0, 16'h0000, 16'h0004, 3'b101, "R11 not");
      // R12 / R1 pass with dirty upper status bits
      drive_exp(5'd17, 16'hBEEF, 16'h0000, 16'hFFFF, 4'h0, 16'hBEEF, 16'h001F, 3'b000, "R12 pass, R1 upper clear");
      drive_exp(5'd25, 16'h1357, 16'hFFFF, 16'h0014, 4'h3, 16'h1357, 16'h0014, 3'b000, "R12 unassigned code");
      // R13 pseudo-random sweep through the reference
      lfsr = 32'h1ACE_B00C;
      for (int i = 0; i < 400; i++) begin
         logic [4:0]  rop;
         logic [15:0] ra, rb, rs;
         lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
         rop = 5'(lfsr[4:0] % 19);
         ra  = lfsr[20:5];
         lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
         rb  = lfsr[31] ? {11'd0, lfsr[4:0]} : lfsr[15:0];
         rs  = lfsr[31:16];
         drive(rop, ra, rb, rs, lfsr[19:16], "R13 random");
      end
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule